// File: doc/BRIEF.md
# Non-Restoring Fractional Divider

This block divides one fixed-point fraction by another over several clock cycles, using the alternating add/subtract method. The method never restores a partial remainder. Each operand is `W` bits wide: one sign bit above `W-1` fraction bits, which gives `n = W-1`. A mode input, sampled on the cycle that starts the operation, chooses how the operands are read:

- **Sign-magnitude mode:** bit `W-1` is the sign and the low `n` bits are the magnitude.
- **Two's-complement mode:** each operand is a two's-complement fraction.

The internal datapath is the same in both modes. It performs one add or subtract per cycle, and the direction of each step comes from the quotient bit found in the step before. Two things are specific to sign-magnitude mode: it works on the magnitudes, and it corrects the final remainder.

A fractional quotient exists only when the dividend's magnitude is smaller than the divisor's. The first trial step tests this. If the test fails, the operation ends at once with the overflow flag set. A zero divisor raises overflow on the start cycle itself, without any iteration.

Results are registered. They stay unchanged until the next operation completes, and a one-cycle `done` pulse marks each new result.

Top module: `nonRestoringDivider`

## Requirements
- R1: After reset, `quotient` and `remainder` are zero and `done` and `overflow` are low.
- R2: In sign-magnitude mode (`tcMode`=0; bit W-1 is the sign, bits W-2..0 the magnitude), the quotient magnitude equals floor(|x|·2^n / |y|), and the quotient sign bit is the XOR of the two operand sign bits.
- R3: In sign-magnitude mode, the remainder magnitude equals (|x|·2^n) mod |y|. It is never negative, because a negative final partial remainder has |y| added back. The remainder sign bit equals the dividend's sign bit.
- R4: In two's-complement mode (`tcMode`=1), the quotient follows the non-restoring rule, and its least significant bit is always 1. The first step subtracts the divisor when the dividend and divisor signs match and adds it otherwise. Each later step subtracts after a 1 bit and adds after a 0 bit. A bit is 1 when the new partial remainder (zero counted as non-negative) has the divisor's sign. The quotient's upper W-1 bits are the first W-1 bits produced, MSB first.
- R5: In two's-complement mode, the remainder is the low W bits of the partial remainder left after the (n+1)-th add/subtract.
- R6: With a nonzero divisor and a nonzero dividend whose magnitude is not smaller than the divisor's, the first step raises `overflow`. `done` is then high in the cycle after the second rising edge counted from the edge that samples `start`, and `quotient` and `remainder` read zero.
- R7: A zero divisor sets `overflow` and `done` in the cycle after the edge that samples `start`. In sign-magnitude mode, a zero divisor is a zero magnitude, which includes 0x80 at W=8.
- R8: A division that does not overflow performs n+1 add/subtract steps and raises `done` after the (W+1)-th rising edge, counting the edge that samples `start`. `done` lasts exactly one cycle.
- R9: `start` has no effect while an operation is in progress. The operands and mode latched at the accepted start decide the result.
- R10: `quotient` and `remainder` hold their values between completions, and `overflow` is low after a completion without overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division; only accepted when idle |
| tcMode | input | 1 | 1 = two's-complement operands, 0 = sign-magnitude |
| dividend | input | W | Dividend fraction |
| divisor | input | W | Divisor fraction |
| quotient | output | W | Quotient fraction |
| remainder | output | W | Remainder, scaled by 2^n relative to the operands |
| done | output | 1 | One-cycle pulse when a result or an overflow is ready |
| overflow | output | 1 | Set by the latest operation when the quotient is not a fraction or the divisor is zero |

## Verification
The hardest condition to reach from the ports is a `start` that arrives while a division is mid-flight. The stimulus for it launches one division, then several cycles later pulses `start` with different operands and the opposite mode. It then confirms that both the timing and the values belong to the first request. The two's-complement boundary cases are driven directly: a divisor of exactly -1, a zero partial remainder, and equal magnitudes of opposite sign. These cases are where the sign rule for a zero remainder and the overflow test on the first step decide the outcome. Random operand pairs with the dividend smaller than the divisor then cover both modes, and each result is compared against an arithmetic or bit-serial model.

// File: rtl/nrDivPkg.sv
package nrDivPkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;    // latch operands, begin an operation
    logic step;    // perform one add/subtract step
    logic first;   // this step is the trial step (no shift)
    logic commit;  // write final quotient and remainder
    logic abort;   // overflow or zero divisor: clear results
  } divStrobes_t;
endpackage

// File: rtl/nrDivCtrl.sv
module nrDivCtrl
  import nrDivPkg::*;
#(
  parameter int W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        zeroDiv,
  input  logic        firstOvf,
  output divStrobes_t strobes,
  output logic        running,
  output logic        done,
  output logic        overflow
);
  localparam int N  = W - 1;
  localparam int CW = $clog2(W);

  logic [CW-1:0] stepCnt;

  always_comb begin
    strobes = '0;
    if (!running) begin
      if (start) begin
        if (zeroDiv) strobes.abort = 1'b1;
        else         strobes.load  = 1'b1;
      end
    end else begin
      strobes.step  = 1'b1;
      strobes.first = (stepCnt == '0);
      if (strobes.first && firstOvf) strobes.abort  = 1'b1;
      else if (stepCnt == CW'(N))    strobes.commit = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      stepCnt  <= '0;
      done     <= 1'b0;
      overflow <= 1'b0;
    end else begin
      done <= strobes.abort | strobes.commit;
      if (strobes.abort)       overflow <= 1'b1;
      else if (strobes.commit) overflow <= 1'b0;
      if (strobes.load) begin
        running <= 1'b1;
        stepCnt <= '0;
      end else if (strobes.abort || strobes.commit) begin
        running <= 1'b0;
      end else if (strobes.step) begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nrDivDatapath.sv
module nrDivDatapath
  import nrDivPkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  divStrobes_t  strobes,
  input  logic         tcMode,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         zeroDiv,
  output logic         firstOvf,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int N  = W - 1;
  localparam int RW = W + 2;  // two guard bits keep 2R +/- D in range

  logic [RW-1:0] opA, opD;
  logic [RW-1:0] acc, dReg, shifted, newR, corrected;
  logic [N-1:0]  mq;
  logic          subNext, aNonZero, modeR, qSign, rSign, bitNow;
  logic [W-1:0]  qFinal, rFinal;

  // operand view per mode: magnitudes or sign-extended values
  always_comb begin
    if (tcMode) begin
      opA = {{2{dividend[W-1]}}, dividend};
      opD = {{2{divisor[W-1]}}, divisor};
    end else begin
      opA = {3'b000, dividend[N-1:0]};
      opD = {3'b000, divisor[N-1:0]};
    end
    zeroDiv = (opD == '0);
  end

  // one add/subtract step
  always_comb begin
    shifted   = strobes.first ? acc : {acc[RW-2:0], 1'b0};
    newR      = subNext ? shifted - dReg : shifted + dReg;
    bitNow    = (newR[RW-1] == dReg[RW-1]);
    firstOvf  = aNonZero && ((newR == '0) || (newR[RW-1] == acc[RW-1]));
    corrected = (!modeR && newR[RW-1]) ? newR + dReg : newR;
    if (modeR) begin
      qFinal = {mq, 1'b1};
      rFinal = newR[W-1:0];
    end else begin
      qFinal = {qSign, mq[N-2:0], bitNow};
      rFinal = {rSign, corrected[N-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc       <= '0;
      dReg      <= '0;
      mq        <= '0;
      subNext   <= 1'b0;
      aNonZero  <= 1'b0;
      modeR     <= 1'b0;
      qSign     <= 1'b0;
      rSign     <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      if (strobes.load) begin
        acc      <= opA;
        dReg     <= opD;
        mq       <= '0;
        subNext  <= (opA[RW-1] == opD[RW-1]);
        aNonZero <= (opA != '0);
        modeR    <= tcMode;
        qSign    <= dividend[W-1] ^ divisor[W-1];
        rSign    <= dividend[W-1];
      end else if (strobes.step) begin
        acc     <= newR;
        mq      <= {mq[N-2:0], bitNow};
        subNext <= bitNow;
      end
      if (strobes.abort) begin
        quotient  <= '0;
        remainder <= '0;
      end else if (strobes.commit) begin
        quotient  <= qFinal;
        remainder <= rFinal;
      end
    end
  end
endmodule

// File: rtl/nonRestoringDivider.sv
module nonRestoringDivider
  import nrDivPkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         tcMode,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         done,
  output logic         overflow
);
  divStrobes_t strobes;
  logic        zeroDiv, firstOvf, running;

  nrDivCtrl #(.W(W)) ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .zeroDiv(zeroDiv), .firstOvf(firstOvf),
    .strobes(strobes), .running(running),
    .done(done), .overflow(overflow)
  );

  nrDivDatapath #(.W(W)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .tcMode(tcMode), .dividend(dividend), .divisor(divisor),
    .zeroDiv(zeroDiv), .firstOvf(firstOvf),
    .quotient(quotient), .remainder(remainder)
  );
endmodule

// File: rtl/nrDivChecker.sv
module nrDivChecker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         running,
  input logic         tcMode,
  input logic [W-1:0] divisor,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         done,
  input logic         overflow
);
  logic zeroIn;
  assign zeroIn = tcMode ? (divisor == '0) : (divisor[W-2:0] == '0);

  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: zero divisor accepted while idle finishes next cycle with overflow
  a_r7_zero_divisor: assert property (@(posedge clk) disable iff (!rstN)
    (!running && start && zeroIn) |=> (done && overflow));

  // R6: an overflowed operation leaves zero results
  a_r6_ovf_zero_out: assert property (@(posedge clk) disable iff (!rstN)
    (done && overflow) |-> (quotient == '0 && remainder == '0));

  // R6: overflow only rises together with done
  a_r6_ovf_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> done);

  // R10: results do not move while an operation is in flight
  a_r10_hold_running: assert property (@(posedge clk) disable iff (!rstN)
    running |-> ($stable(quotient) && $stable(remainder)));

  // R9: no completion is reported while idle without a request
  a_r9_no_spurious_done: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !start) |=> !done);
endmodule

bind nonRestoringDivider nrDivChecker #(.W(W)) chk (
  .clk(clk), .rstN(rstN), .start(start), .running(running),
  .tcMode(tcMode), .divisor(divisor), .quotient(quotient),
  .remainder(remainder), .done(done), .overflow(overflow)
);

// File: tb/nonRestoringDivider_test.sv
module nonRestoringDivider_test;
  localparam int W = 8;
  localparam int N = W - 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         tcMode = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic [W-1:0] quotient, remainder;
  logic         done, overflow;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  nonRestoringDivider #(.W(W)) uut (
    .clk(clk), .rstN(rstN), .start(start), .tcMode(tcMode),
    .dividend(dividend), .divisor(divisor),
    .quotient(quotient), .remainder(remainder),
    .done(done), .overflow(overflow)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int toSigned(input logic [W-1:0] v);
    return v[W-1] ? int'(v) - (1 << W) : int'(v);
  endfunction

  // reference: arithmetic for sign-magnitude, bit-serial rule for two's complement
  task automatic model(input logic mode, input logic [W-1:0] x, input logic [W-1:0] y,
                       output logic ovf, output logic [W-1:0] q, output logic [W-1:0] r,
                       output int cyc);
    ovf = 1'b0; q = '0; r = '0;
    if (!mode) begin
      int xm = int'(x[N-1:0]);
      int ym = int'(y[N-1:0]);
      if (ym == 0) begin ovf = 1'b1; cyc = 1; end
      else if (xm >= ym) begin ovf = 1'b1; cyc = 2; end
      else begin
        int qm = (xm << N) / ym;
        int rm = (xm << N) % ym;
        q = {x[W-1] ^ y[W-1], qm[N-1:0]};
        r = {x[W-1], rm[N-1:0]};
        cyc = W + 1;
      end
    end else begin
      int a = toSigned(x);
      int d = toSigned(y);
      int aa = (a < 0) ? -a : a;
      int dd = (d < 0) ? -d : d;
      if (d == 0) begin ovf = 1'b1; cyc = 1; end
      else if (a != 0 && aa >= dd) begin ovf = 1'b1; cyc = 2; end
      else begin
        int rr = 0;
        int qv = 0;
        bit prev = 1'b0;
        for (int k = 0; k <= N; k++) begin
          bit b;
          if (k == 0) rr = a + (((a < 0) == (d < 0)) ? -d : d);
          else        rr = 2 * rr + (prev ? -d : d);
          b = ((rr < 0) == (d < 0));
          if (k < N) qv = (qv << 1) | int'(b);
          prev = b;
        end
        qv = (qv << 1) | 1;
        q = qv[W-1:0];
        r = rr[W-1:0];
        cyc = W + 1;
      end
    end
  endtask

  // drive one request and count rising edges until done is seen
  task automatic runOp(input logic mode, input logic [W-1:0] x, input logic [W-1:0] y, output int cyc);
    @(negedge clk);
    tcMode = mode; dividend = x; divisor = y; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 100) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic opAndCheck(input logic mode, input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
    logic ovf;
    logic [W-1:0] q, r;
    int ec, cyc;
    model(mode, x, y, ovf, q, r, ec);
    runOp(mode, x, y, cyc);
    check(cyc == ec, {tag, " R8 cycles"}, cyc, ec);
    check(overflow == ovf, {tag, " R6 overflow"}, overflow, ovf);
    check(quotient == q, {tag, mode ? " R4 quotient" : " R2 quotient"}, quotient, q);
    check(remainder == r, {tag, mode ? " R5 remainder" : " R3 remainder"}, remainder, r);
    @(negedge clk);
    check(done == 1'b0, {tag, " R8 done one cycle"}, done, 0);
  endtask

  task automatic testReset();
    check(quotient == '0, "R1 quotient", quotient, 0);
    check(remainder == '0, "R1 remainder", remainder, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check(overflow == 1'b0, "R1 overflow", overflow, 0);
  endtask

  task automatic testSignMag();
    int cyc;
    runOp(1'b0, 8'h30, 8'h50, cyc);
    check(quotient == 8'h4C, "R2 fixed quotient", quotient, 8'h4C);
    check(remainder == 8'h40, "R3 fixed remainder", remainder, 8'h40);
    check(overflow == 1'b0, "R10 overflow low", overflow, 0);
    opAndCheck(1'b0, 8'hB0, 8'h50, "sm neg dividend");
    opAndCheck(1'b0, 8'h30, 8'hD0, "sm neg divisor");
    opAndCheck(1'b0, 8'h85, 8'h07, "sm neg both");
    opAndCheck(1'b0, 8'h00, 8'h7F, "sm zero dividend");
    opAndCheck(1'b0, 8'h7E, 8'h7F, "sm near one");
  endtask

  task automatic testOverflow();
    opAndCheck(1'b0, 8'h50, 8'h50, "R6 sm equal");
    opAndCheck(1'b0, 8'hE0, 8'h10, "R6 sm larger");
    opAndCheck(1'b1, 8'hC0, 8'h40, "R6 tc equal opposite");
    opAndCheck(1'b1, 8'h60, 8'h20, "R6 tc larger");
    opAndCheck(1'b1, 8'h80, 8'h80, "R6 tc minus one");
    check(quotient == '0 && remainder == '0, "R6 zero results", {quotient, remainder}, 0);
  endtask

  task automatic testZeroDiv();
    opAndCheck(1'b0, 8'h10, 8'h00, "R7 sm zero");
    opAndCheck(1'b0, 8'h10, 8'h80, "R7 sm negative zero");
    opAndCheck(1'b1, 8'h10, 8'h00, "R7 tc zero");
  endtask

  task automatic testTwos();
    opAndCheck(1'b1, 8'h40, 8'h80, "tc divisor minus one");
    check(quotient[0] == 1'b1, "R4 lsb forced", quotient[0], 1);
    opAndCheck(1'b1, 8'h40, 8'hA0, "tc pos over neg");
    opAndCheck(1'b1, 8'hD0, 8'h60, "tc neg over pos");
    opAndCheck(1'b1, 8'hE0, 8'hC0, "tc neg over neg");
    opAndCheck(1'b1, 8'h20, 8'h40, "tc zero partial");
    opAndCheck(1'b1, 8'h00, 8'hC0, "tc zero dividend");
    check(quotient[0] == 1'b1, "R4 lsb forced zero dividend", quotient[0], 1);
  endtask

  task automatic testBusyIgnore();
    logic ovf;
    logic [W-1:0] q, r;
    int ec, cyc;
    model(1'b0, 8'h30, 8'h50, ovf, q, r, ec);
    @(negedge clk);
    tcMode = 1'b0; dividend = 8'h30; divisor = 8'h50; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    repeat (3) begin @(posedge clk); @(negedge clk); cyc++; end
    tcMode = 1'b1; dividend = 8'h10; divisor = 8'h00; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    start = 1'b0;
    while (!done && cyc < 100) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    check(cyc == ec, "R9 cycles unchanged", cyc, ec);
    check(quotient == q && remainder == r, "R9 result of first request", {quotient, remainder}, {q, r});
    check(overflow == 1'b0, "R9 no overflow from ignored start", overflow, 0);
  endtask

  task automatic testHold();
    logic [W-1:0] q0, r0;
    q0 = quotient; r0 = remainder;
    @(negedge clk);
    dividend = 8'h7F; divisor = 8'h01; tcMode = ~tcMode;
    repeat (5) @(negedge clk);
    check(quotient == q0 && remainder == r0, "R10 results held", {quotient, remainder}, {q0, r0});
    check(done == 1'b0, "R10 done stays low", done, 0);
  endtask

  task automatic testRandom();
    for (int i = 0; i < 150; i++) begin
      int ym = 1 + int'($urandom % ((1 << N) - 1));
      int xm = int'($urandom % ym);
      logic [W-1:0] x, y;
      x = {1'($urandom), xm[N-1:0]};
      y = {1'($urandom), ym[N-1:0]};
      opAndCheck(1'b0, x, y, "random sm");
    end
    for (int i = 0; i < 150; i++) begin
      int dm = 1 + int'($urandom % ((1 << N) - 1));
      int am = int'($urandom % dm);
      int a = ($urandom % 2) ? -am : am;
      int d = ($urandom % 2) ? -dm : dm;
      opAndCheck(1'b1, a[W-1:0], d[W-1:0], "random tc");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSignMag();
    testOverflow();
    testZeroDiv();
    testTwos();
    testBusyIgnore();
    testHold();
    testRandom();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule